// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

The block receives frames as a byte stream. Each byte is tagged as the last of its frame or not, and a small error side-band comes with the last byte. Each frame goes into the buffer named by the current descriptor of a power-of-two ring held in system memory. The engine first reads the descriptor's control word. If the ownership bit gives the entry to the engine, it fetches the buffer address and streams the frame into the buffer as 32-bit little-endian words. It then writes the byte count and, last of all, a status that hands the entry back to the host.

A descriptor takes 16 bytes, and entry *n* sits at ring base + 16·*n*. The word at +0 is the buffer address. The word at +4 carries the negated buffer size in bits 15:0 and the status in bits 31:16. The word at +8 carries the received byte count in bits 11:0. The word at +12 is unused. The host re-arms an entry by setting status bit 15 (word bit 31) again. When a frame arrives and the current entry is not owned, the frame is consumed and discarded, and a missed-frame count advances.

Top module: `rx_ring_writer`

## Requirements
- R1: Before a frame is accepted, the engine reads the word at descriptor +4. Word bit 31 set means the entry may be filled: the engine reads the buffer address at +0 and then accepts bytes. While a descriptor read is outstanding, `s_ready` stays low.
- R2: Accepted bytes go to consecutive buffer addresses, four per 32-bit write, with byte k of the frame in lane k mod 4. A final partial word is written with only its filled lanes set in `mem_wstrb`, and its empty lanes read as zero.
- R3: Frame bytes beyond the buffer size (the two's complement negation of bits 15:0 of the +4 word, capped at 4095) are discarded, and the status sets overflow flag 0x10 in its high byte.
- R4: A frame without errors ends with a write to +4 with `mem_wstrb`=4'b1100. Its data has the high status byte equal to 0x03 (start and end markers), the ownership bit 31 clear, and all other bits zero.
- R5: The error side-band `s_err` is taken with the last byte and mapped into the high status byte as follows: bit 0 gives framing 0x20, bit 1 gives CRC 0x08, and bit 2 gives buffer error 0x04. The 0x03 markers stay set.
- R6: The word written at +8 holds in bits 11:0 the number of bytes stored, FCS included, with bits 31:12 zero.
- R7: For each frame the writes come in this order: all buffer words, then the length word, then the status word, and none of them is repeated.
- R8: The ring has 2^`cfg_ring_log2` entries, capped at 2^MAX_RING_LOG2. The entry index steps by one per completed frame and wraps from the last entry to entry 0.
- R9: A frame that meets a non-owned entry is accepted to its last byte and makes no memory write. `missed_count` rises by exactly one, and the same entry is read again for the next frame.
- R10: A memory request holds its address, direction and write data unchanged until `mem_gnt` is seen.
- R11: After reset, `s_ready` and `mem_req` are low, `missed_count` is zero, and the ring index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ring_base | input | AW | Byte address of descriptor 0 (16-byte aligned) |
| cfg_ring_log2 | input | 4 | Ring size exponent (the field from bits 7:4 of the packed ring-length word) |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of the frame |
| s_err | input | 3 | End-of-frame errors: bit0 framing, bit1 CRC, bit2 buffer |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_wstrb | output | 4 | Byte lane enables for writes |
| mem_rvalid | input | 1 | Read data valid, one per granted read |
| mem_rdata | input | 32 | Read data |
| missed_count | output | MISS_W | Frames dropped for lack of an owned entry, wrapping |

## Verification
The assertions assume three things about the inputs. `mem_rvalid` arrives only after a granted read, with exactly one response per read. The ring base and size stay fixed while frames flow. The stream keeps `s_valid` and its byte steady until they are accepted. The stimulus applies the configuration before reset is released and never changes it afterwards. Its memory model answers every granted read exactly one cycle later and grants with a pseudo-random delay. The driver holds each byte until `s_ready` has taken it, and it re-arms descriptors only while the engine waits between frames.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_CTRL,
        S_RD_CTRL_W,
        S_RD_BUF,
        S_RD_BUF_W,
        S_RECV,
        S_WR_DATA,
        S_WR_LEN,
        S_WR_STAT,
        S_DROP
    } rx_state_e;

    // descriptor layout (byte offsets within one entry)
    localparam int DESC_SHIFT = 4;
    localparam int OFS_BUF    = 0;
    localparam int OFS_CTRL   = 4;
    localparam int OFS_LEN    = 8;

    // bit of the control word that grants the entry to the engine
    localparam int OWN_BIT    = 31;

    // flag positions inside the status high byte
    localparam int HB_FRAM    = 5;
    localparam int HB_OFLO    = 4;
    localparam int HB_CRC     = 3;
    localparam int HB_BUFE    = 2;
    localparam int HB_STP     = 1;
    localparam int HB_ENP     = 0;

    localparam int LEN_W      = 12;

endpackage

// File: rtl/rx_byte_packer.sv
module rx_byte_packer #(
    parameter int DW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     push,
    input  logic [7:0]               din,
    output logic [DW-1:0]            word,
    output logic [DW/8-1:0]          strb,
    output logic [$clog2(DW/8):0]    fill
);
    localparam int NB = DW / 8;
    localparam int LW = $clog2(NB) + 1;

    typedef struct packed {
        logic [DW-1:0] word;
        logic [LW-1:0] fill;
    } pk_t;

    pk_t pk_d, pk_q;

    always_comb begin
        pk_d = pk_q;
        if (clear) begin
            pk_d.word = '0;
            pk_d.fill = '0;
        end else if (push) begin
            for (int b = 0; b < NB; b++) begin
                if (pk_q.fill == LW'(b)) pk_d.word[b*8 +: 8] = din;
            end
            pk_d.fill = pk_q.fill + LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word = pk_q.word;
    assign fill = pk_q.fill;

    for (genvar g = 0; g < NB; g++) begin : g_strb
        assign strb[g] = (pk_q.fill > LW'(g));
    end

    // R2: the word never holds more than NB bytes and is never pushed when full
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.fill <= LW'(NB)) && !(push && !clear && pk_q.fill == LW'(NB)));

endmodule

// File: rtl/rx_ring_index.sv
module rx_ring_index #(
    parameter int MAX_LOG2 = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          log2_sz,
    input  logic                advance,
    output logic [MAX_LOG2-1:0] idx
);
    localparam int IW = MAX_LOG2;

    logic [3:0]  eff_log2;
    logic [IW:0] span;
    logic [IW-1:0] last;
    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        eff_log2 = (32'(log2_sz) > MAX_LOG2) ? 4'(MAX_LOG2) : log2_sz;
        span     = (IW+1)'(1) << eff_log2;
        last     = IW'(span - (IW+1)'(1));
        idx_d    = idx_q;
        if (advance) idx_d = (idx_q == last) ? '0 : idx_q + IW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;

    // R8: the index stays inside the configured ring
    a_r8_idx_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= last);

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rx_ring_pkg::*;
#(
    parameter int AW            = 32,
    parameter int MAX_RING_LOG2 = 8,
    parameter int MISS_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_ring_base,
    input  logic [3:0]        cfg_ring_log2,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic [2:0]        s_err,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_wstrb,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic [MISS_W-1:0] missed_count
);
    localparam int DW     = 32;
    localparam int NB     = DW / 8;
    localparam int LW     = $clog2(NB) + 1;
    localparam int WOFS_W = LEN_W - $clog2(NB);

    typedef struct packed {
        rx_state_e          st;
        logic [15:0]        buflen;
        logic [AW-1:0]      bufbase;
        logic [LEN_W-1:0]   cnt;
        logic [WOFS_W-1:0]  wofs;
        logic               ovf;
        logic [2:0]         err;
        logic               done;
        logic [MISS_W-1:0]  missed;
    } regs_t;

    regs_t r_d, r_q;

    logic [MAX_RING_LOG2-1:0] idx;
    logic                     idx_adv;
    logic [AW-1:0]            desc_addr;
    logic [15:0]              bufsz;
    logic [LEN_W-1:0]         lim;
    logic                     pk_push, pk_clear;
    logic [DW-1:0]            pk_word;
    logic [NB-1:0]            pk_strb;
    logic [LW-1:0]            pk_fill;
    logic [LW-1:0]            fill_after;
    logic                     store;
    logic [7:0]               stat_hb;

    rx_ring_index #(.MAX_LOG2(MAX_RING_LOG2)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .log2_sz (cfg_ring_log2),
        .advance (idx_adv),
        .idx     (idx)
    );

    rx_byte_packer #(.DW(DW)) u_packer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pk_clear),
        .push  (pk_push),
        .din   (s_data),
        .word  (pk_word),
        .strb  (pk_strb),
        .fill  (pk_fill)
    );

    assign desc_addr = cfg_ring_base + (AW'(idx) << DESC_SHIFT);
    assign bufsz     = 16'(~r_q.buflen + 16'd1);
    assign lim       = (bufsz > 16'(2**LEN_W - 1)) ? {LEN_W{1'b1}} : bufsz[LEN_W-1:0];

    always_comb begin
        stat_hb          = '0;
        stat_hb[HB_FRAM] = r_q.err[0];
        stat_hb[HB_OFLO] = r_q.ovf;
        stat_hb[HB_CRC]  = r_q.err[1];
        stat_hb[HB_BUFE] = r_q.err[2];
        stat_hb[HB_STP]  = 1'b1;
        stat_hb[HB_ENP]  = 1'b1;
    end

    always_comb begin
        r_d        = r_q;
        s_ready    = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        mem_wstrb  = '0;
        pk_push    = 1'b0;
        pk_clear   = 1'b0;
        idx_adv    = 1'b0;
        store      = 1'b0;
        fill_after = pk_fill;

        case (r_q.st)
            S_IDLE: begin
                if (s_valid) r_d.st = S_RD_CTRL;
            end
            S_RD_CTRL: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(OFS_CTRL);
                if (mem_gnt) r_d.st = S_RD_CTRL_W;
            end
            S_RD_CTRL_W: begin
                if (mem_rvalid) begin
                    r_d.buflen = mem_rdata[15:0];
                    r_d.st     = mem_rdata[OWN_BIT] ? S_RD_BUF : S_DROP;
                end
            end
            S_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(OFS_BUF);
                if (mem_gnt) r_d.st = S_RD_BUF_W;
            end
            S_RD_BUF_W: begin
                if (mem_rvalid) begin
                    r_d.bufbase = AW'(mem_rdata);
                    r_d.st      = S_RECV;
                end
            end
            S_RECV: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    store      = (r_q.cnt < lim);
                    pk_push    = store;
                    fill_after = pk_fill + (store ? LW'(1) : LW'(0));
                    if (store) r_d.cnt = r_q.cnt + LEN_W'(1);
                    else       r_d.ovf = 1'b1;
                    if (s_last) begin
                        r_d.err  = s_err;
                        r_d.done = 1'b1;
                        r_d.st   = (fill_after != '0) ? S_WR_DATA : S_WR_LEN;
                    end else if (fill_after == LW'(NB)) begin
                        r_d.st = S_WR_DATA;
                    end
                end
            end
            S_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.bufbase + (AW'(r_q.wofs) << $clog2(NB));
                mem_wdata = pk_word;
                mem_wstrb = pk_strb;
                if (mem_gnt) begin
                    pk_clear = 1'b1;
                    r_d.wofs = r_q.wofs + WOFS_W'(1);
                    r_d.st   = r_q.done ? S_WR_LEN : S_RECV;
                end
            end
            S_WR_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + AW'(OFS_LEN);
                mem_wdata = 32'(r_q.cnt);
                mem_wstrb = 4'b1111;
                if (mem_gnt) r_d.st = S_WR_STAT;
            end
            S_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + AW'(OFS_CTRL);
                mem_wdata = {stat_hb, 8'h00, 16'h0000};
                mem_wstrb = 4'b1100;
                if (mem_gnt) begin
                    idx_adv  = 1'b1;
                    r_d.cnt  = '0;
                    r_d.wofs = '0;
                    r_d.ovf  = 1'b0;
                    r_d.err  = '0;
                    r_d.done = 1'b0;
                    r_d.st   = S_IDLE;
                end
            end
            S_DROP: begin
                s_ready = 1'b1;
                if (s_valid && s_last) begin
                    r_d.missed = r_q.missed + MISS_W'(1);
                    r_d.st     = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign missed_count = r_q.missed;

    // R10: an ungranted request is held unchanged into the next cycle
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata) && $stable(mem_wstrb)));

    // R4: a status write gives the entry back with both markers set
    a_r4_status_released: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr == desc_addr + AW'(OFS_CTRL))
            |-> (!mem_wdata[OWN_BIT] && mem_wdata[25:24] == 2'b11 && mem_wdata[23:0] == '0));

    // R7: nothing is requested in the cycle after the status write is granted
    a_r7_status_last: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_gnt && mem_addr == desc_addr + AW'(OFS_CTRL)) |=> !mem_req);

    // R6: the length written never exceeds the usable buffer size
    a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr == desc_addr + AW'(OFS_LEN))
            |-> (mem_wdata[31:LEN_W] == '0 && mem_wdata[LEN_W-1:0] <= lim));

    // R3: the stored byte count never passes the buffer limit
    a_r3_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_RECV) |-> (r_q.cnt <= lim));

    // R9: the missed count only ever steps by one
    a_r9_missed_step: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_count != $past(missed_count)) |-> (missed_count == $past(missed_count) + MISS_W'(1)));

    // R1: no stream byte is taken while a descriptor read is outstanding
    a_r1_hold_stream: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !s_ready);

endmodule

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;
    localparam int RING_BASE = 32'h100;
    localparam int BUF_BASE  = 32'h400;
    localparam int BUF_SIZE  = 64;
    localparam int RING_N    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_ring_base = RING_BASE;
    logic [3:0]  cfg_ring_log2 = 4'd2;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [7:0]  s_data = '0;
    logic        s_last = 1'b0;
    logic [2:0]  s_err = '0;
    logic        mem_req;
    logic        mem_gnt = 1'b0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_wstrb;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [15:0] missed_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] mem [0:1023];
    logic [31:0] exp_addr [$];
    logic [31:0] exp_data [$];
    logic [3:0]  exp_strb [$];
    string       exp_tag  [$];
    int          bidx = 0;

    always #4 clk = ~clk;

    rx_ring_writer i_rx_ring_writer (
        .clk(clk), .rst_n(rst_n),
        .cfg_ring_base(cfg_ring_base), .cfg_ring_log2(cfg_ring_log2),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_last(s_last), .s_err(s_err),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .missed_count(missed_count)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // memory model and write monitor (scoreboard consumer)
    logic [7:0]  lfsr = 8'hA5;
    logic        rd_pend = 1'b0;
    logic [31:0] rd_data = '0;
    always @(negedge clk) begin
        mem_rvalid = rd_pend;
        mem_rdata  = rd_pend ? rd_data : 32'h0;
        rd_pend    = 1'b0;
        lfsr       = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_gnt    = rst_n && mem_req && (lfsr[0] | lfsr[1]);
        if (mem_gnt) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_wstrb[b]) mem[mem_addr[11:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
                if (exp_addr.size() == 0) begin
                    check(1'b0, "R9 R7 unexpected write", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] ea, ed;
                    logic [3:0]  es;
                    string       et;
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    es = exp_strb.pop_front();
                    et = exp_tag.pop_front();
                    check(mem_addr == ea, {et, " R7 address"}, mem_addr, ea);
                    check(mem_wdata == ed, {et, " data"}, mem_wdata, ed);
                    check(mem_wstrb == es, {et, " strobe"}, 32'(mem_wstrb), 32'(es));
                end
            end else begin
                rd_pend = 1'b1;
                rd_data = mem[mem_addr[11:2]];
            end
        end
    end

    function automatic logic [7:0] fbyte(input int tag, input int i);
        return 8'(tag * 16 + i);
    endfunction

    task automatic arm(input int e);
        mem[(RING_BASE + 16*e) / 4 + 0] = BUF_BASE + 32'h100 * e;
        mem[(RING_BASE + 16*e) / 4 + 1] = {16'h8000, 16'(-BUF_SIZE)};
        mem[(RING_BASE + 16*e) / 4 + 2] = 32'h0;
    endtask

    // driver: pushes the expected writes, then streams the frame
    task automatic send_frame(input int len, input int tag, input logic [2:0] err, input bit owned);
        if (owned) begin
            int n, nw;
            logic [7:0] hb;
            string st_tag;
            n  = (len < BUF_SIZE) ? len : BUF_SIZE;
            nw = (n + 3) / 4;
            for (int w = 0; w < nw; w++) begin
                logic [31:0] d;
                logic [3:0]  s;
                d = '0; s = '0;
                for (int b = 0; b < 4; b++)
                    if (4*w + b < n) begin
                        d[b*8 +: 8] = fbyte(tag, 4*w + b);
                        s[b] = 1'b1;
                    end
                exp_addr.push_back(BUF_BASE + 32'h100 * bidx + 4*w);
                exp_data.push_back(d);
                exp_strb.push_back(s);
                exp_tag.push_back("R2");
            end
            exp_addr.push_back(RING_BASE + 16*bidx + 8);
            exp_data.push_back(32'(n));
            exp_strb.push_back(4'hF);
            exp_tag.push_back(len > BUF_SIZE ? "R3 R6 length" : "R6 length");
            hb = 8'h03 | {2'b00, err[0], (len > BUF_SIZE), err[1], err[2], 2'b00};
            st_tag = (len > BUF_SIZE) ? "R3 status" : (err != 0) ? "R5 status" : "R4 status";
            exp_addr.push_back(RING_BASE + 16*bidx + 4);
            exp_data.push_back({hb, 24'h0});
            exp_strb.push_back(4'b1100);
            exp_tag.push_back(st_tag);
            bidx = (bidx + 1) % RING_N;   // R8 wrap in the model
        end
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            bit r;
            s_valid = 1'b1;
            s_data  = fbyte(tag, i);
            s_last  = (i == len - 1);
            s_err   = (i == len - 1) ? err : 3'b000;
            do begin
                r = s_ready;
                @(negedge clk);
            end while (!r);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
        s_err   = '0;
        while (exp_addr.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        for (int e = 0; e < RING_N; e++) arm(e);
        repeat (3) @(negedge clk);
        // R11: reset state
        check(s_ready == 1'b0, "R11 s_ready", 32'(s_ready), 0);
        check(mem_req == 1'b0, "R11 mem_req", 32'(mem_req), 0);
        check(missed_count == 0, "R11 missed_count", 32'(missed_count), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(s_ready == 1'b0, "R1 idle not ready", 32'(s_ready), 0);

        send_frame(60, 1, 3'b000, 1'b1);   // R2 R4 R6, entry 0
        send_frame(61, 2, 3'b010, 1'b1);   // R5 CRC, partial word, entry 1
        send_frame(70, 3, 3'b000, 1'b1);   // R3 truncation, entry 2
        send_frame(5,  4, 3'b101, 1'b1);   // R5 framing + buffer, entry 3
        // R9: entry 0 is now host-owned again only after re-arm
        send_frame(12, 5, 3'b000, 1'b0);
        check(missed_count == 1, "R9 missed after drop", 32'(missed_count), 1);
        arm(0);
        arm(1);
        send_frame(8, 6, 3'b000, 1'b1);    // R8 wrapped to entry 0, R9 retry
        send_frame(4, 7, 3'b001, 1'b1);    // exactly one word, entry 1
        send_frame(9, 8, 3'b000, 1'b0);    // entry 2 still not owned
        check(missed_count == 2, "R9 missed second drop", 32'(missed_count), 2);
        check(mem[(RING_BASE + 16*2 + 8) / 4] == 32'd64, "R3 stored length in memory",
              mem[(RING_BASE + 16*2 + 8) / 4], 32'd64);
        check(exp_addr.size() == 0, "R7 all writes seen", 32'(exp_addr.size()), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule